// File: doc/BRIEF.md
# Multicycle 8-bit Stored-Program Processor

This block is a small processor that executes programs held in a 256-byte unified memory. Each instruction is 16 bits wide. It is stored as two neighbouring bytes, and the byte at the lower address supplies the upper half. The upper nibble selects the operation. The other three nibbles are 4-bit operand fields: a register number, a second register number and a third one, or a register number followed by an 8-bit address or constant. The processor has sixteen 8-bit general registers, an 8-bit program counter and a 16-bit instruction register. A controller steps through two fetch states, a decode state and an execute state.

Programs reach the core through a byte-wide memory port. The core drives an address, write data and a write strobe. The memory must return the read byte in the same cycle, and a write takes effect at the clock edge. This port has no handshake and no back-pressure, because the memory always answers within the cycle. The `run` input allows fetching. The `halted` output reports that execution has stopped, and it stays high until the next reset. The `illegal` output reports that execution stopped on an undefined operation.

Top module: `byte_cpu`

## Requirements
- R1: After reset the core reads the byte at PC as instruction bits 15:8 and then the byte at PC+1 as bits 7:0. PC then grows by 2. Every instruction except rotate and halt takes exactly 4 clocks.
- R2: Opcode 1 (fields R, XY) copies memory[XY] into register R. Opcode 2 (fields R, XY) writes the constant XY into register R. R is in bits 11:8 and XY is in bits 7:0.
- R3: Opcode 3 (fields R, XY) writes register R to memory[XY].
- R4: Opcode 4 (bits 11:8 zero, source register in bits 7:4, destination register in bits 3:0) copies the source register into the destination register.
- R5: Opcode 5 writes the sum of registers S (bits 7:4) and T (bits 3:0), taken modulo 256, to register R (bits 11:8).
- R6: Opcodes 7, 8 and 9 write the OR, AND and XOR of registers S and T to register R, with the same field positions as R5.
- R7: Opcode A (register R in bits 11:8, count X in bits 3:0) rotates register R right X times. On each step bit 0 moves to bit 7. A count of 0 leaves R unchanged. The core rotates one bit per clock, so the instruction takes X+4 clocks.
- R8: Opcode B (fields R, XY) loads PC with XY when register R equals register 0. Otherwise execution continues at the next instruction.
- R9: Opcode C halts the core 3 clocks after its fetch begins. `halted` then stays high, no memory write occurs and the address output holds still until reset.
- R10: Opcodes 0, 6, D, E and F set `illegal` together with `halted`. No memory write occurs afterwards and no later instruction executes.
- R11: A synchronous reset clears PC and all sixteen registers to 00h, enters the first fetch state and drops `halted` and `illegal`.
- R12: While `run` is low in the first fetch state, the core does not advance. PC, the address output and memory all stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Allows the next instruction fetch |
| mem_rdata | input | 8 | Byte read from memory at mem_addr, same cycle |
| mem_addr | output | 8 | Memory byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe, one clock per store |
| halted | output | 1 | Execution stopped, held until reset |
| illegal | output | 1 | Stopped on an undefined opcode |

## Verification
The bench goes after these corner cases:
- Rotate counts of 0 and 15, and the exact clock count of a rotate. A core that rotated once too often or too few times, or treated a count of 0 as 16, would store the wrong byte or reach `halted` on the wrong cycle.
- The jump both when its condition holds and when it does not. An inverted comparison would store the byte from the wrong path.
- Each undefined opcode. A core that did not stop on one would execute the store that follows it.
- Holding `run` low and re-entering reset. A core that ignored `run` would change memory early. One that did not clear its registers would store stale values.
- Additions that overflow and random logic operands, compared against values the bench computes.

// File: rtl/bcpu_pkg.sv
package bcpu_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int FW = 4;
  localparam int NREG = 1 << FW;

  localparam logic [FW-1:0] OP_LDM = 4'h1;
  localparam logic [FW-1:0] OP_LDI = 4'h2;
  localparam logic [FW-1:0] OP_STM = 4'h3;
  localparam logic [FW-1:0] OP_MOV = 4'h4;
  localparam logic [FW-1:0] OP_ADD = 4'h5;
  localparam logic [FW-1:0] OP_OR  = 4'h7;
  localparam logic [FW-1:0] OP_AND = 4'h8;
  localparam logic [FW-1:0] OP_XOR = 4'h9;
  localparam logic [FW-1:0] OP_ROR = 4'hA;
  localparam logic [FW-1:0] OP_JEQ = 4'hB;
  localparam logic [FW-1:0] OP_HLT = 4'hC;

  typedef enum logic [2:0] {ST_FHI, ST_FLO, ST_DEC, ST_EXE, ST_HLT} state_e;
  typedef enum logic [2:0] {ALU_ADD, ALU_OR, ALU_AND, ALU_XOR, ALU_ROR, ALU_PASS} alu_op_e;
endpackage

// File: rtl/bcpu_regfile.sv
module bcpu_regfile #(
  parameter int W  = 8,
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [IW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/bcpu_alu.sv
module bcpu_alu import bcpu_pkg::*; #(
  parameter int W = DW
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_OR:  y = a | b;
      ALU_AND: y = a & b;
      ALU_XOR: y = a ^ b;
      ALU_ROR: y = {a[0], a[W-1:1]};
      default: y = a;
    endcase
  end
endmodule

// File: rtl/bcpu_ctrl.sv
module bcpu_ctrl import bcpu_pkg::*; #(
  parameter int W  = DW,
  parameter int A  = AW,
  parameter int F  = FW,
  localparam int IRW = 4 * F
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] mem_rdata,
  input  logic [W-1:0] rd_a,
  input  logic [W-1:0] rd_b,
  input  logic [W-1:0] alu_y,
  output logic [A-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  output logic [F-1:0] ra,
  output logic [F-1:0] rb,
  output logic         rf_we,
  output logic [F-1:0] rf_waddr,
  output logic [W-1:0] rf_wdata,
  output alu_op_e      alu_op,
  output logic         halted,
  output logic         illegal
);
  state_e         state;
  logic [A-1:0]   pc;
  logic [IRW-1:0] ir;
  logic [F-1:0]   cnt;
  logic           ill_q;

  logic [F-1:0] op, fr, fs, ft;
  logic [A-1:0] xy;
  logic         known_op, alu_form;

  assign op = ir[4*F-1 -: F];
  assign fr = ir[3*F-1 -: F];
  assign fs = ir[2*F-1 -: F];
  assign ft = ir[F-1:0];
  assign xy = ir[A-1:0];

  assign known_op = op inside {OP_LDM, OP_LDI, OP_STM, OP_MOV, OP_ADD, OP_OR,
                               OP_AND, OP_XOR, OP_ROR, OP_JEQ, OP_HLT};
  assign alu_form = op inside {OP_ADD, OP_OR, OP_AND, OP_XOR};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FHI;
      pc    <= '0;
      ir    <= '0;
      cnt   <= '0;
      ill_q <= 1'b0;
    end else begin
      case (state)
        ST_FHI: if (run) begin
          ir[IRW-1 -: W] <= mem_rdata;
          state <= ST_FLO;
        end
        ST_FLO: begin
          ir[W-1:0] <= mem_rdata;
          pc    <= pc + A'(2);
          state <= ST_DEC;
        end
        ST_DEC: begin
          cnt <= ft;
          if (op == OP_HLT) state <= ST_HLT;
          else if (!known_op) begin
            ill_q <= 1'b1;
            state <= ST_HLT;
          end else state <= ST_EXE;
        end
        ST_EXE: begin
          if (op == OP_ROR && cnt != '0) begin
            cnt <= cnt - F'(1);
          end else begin
            if (op == OP_JEQ && rd_a == rd_b) pc <= xy;
            state <= ST_FHI;
          end
        end
        default: state <= ST_HLT;
      endcase
    end
  end

  always_comb begin
    mem_addr = pc;
    if (state == ST_FLO) mem_addr = pc + A'(1);
    else if (state == ST_EXE && (op == OP_LDM || op == OP_STM)) mem_addr = xy;
  end

  assign mem_we    = (state == ST_EXE) && (op == OP_STM);
  assign mem_wdata = rd_a;

  always_comb begin
    ra = fr;
    rb = ft;
    if (alu_form || op == OP_MOV) ra = fs;
    if (op == OP_JEQ) rb = '0;
  end

  assign rf_we = (state == ST_EXE) &&
                 ((op inside {OP_LDM, OP_LDI, OP_MOV}) || alu_form ||
                  (op == OP_ROR && cnt != '0));
  assign rf_waddr = (op == OP_MOV) ? ft : fr;

  always_comb begin
    case (op)
      OP_LDM:  rf_wdata = mem_rdata;
      OP_LDI:  rf_wdata = xy;
      default: rf_wdata = alu_y;
    endcase
  end

  always_comb begin
    case (op)
      OP_ADD:  alu_op = ALU_ADD;
      OP_OR:   alu_op = ALU_OR;
      OP_AND:  alu_op = ALU_AND;
      OP_XOR:  alu_op = ALU_XOR;
      OP_ROR:  alu_op = ALU_ROR;
      default: alu_op = ALU_PASS;
    endcase
  end

  assign halted  = (state == ST_HLT);
  assign illegal = ill_q;

  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FLO) |=> (pc == $past(pc) + A'(2)));
  // R7
  rot_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXE && op == OP_ROR && cnt != '0) |=> (state == ST_EXE && cnt == $past(cnt) - F'(1)));
  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && $stable(mem_addr)));
  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);
  // R10
  ill_halt_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> halted);
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FHI && !run) |=> (state == ST_FHI && $stable(pc)));
  // R3
  store_once_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (!mem_we && state == ST_FHI));
endmodule

// File: rtl/byte_cpu.sv
module byte_cpu import bcpu_pkg::*; (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          halted,
  output logic          illegal
);
  logic [DW-1:0] rd_a, rd_b, alu_y, rf_wdata;
  logic [FW-1:0] ra, rb, rf_waddr;
  logic          rf_we;
  alu_op_e       alu_op;

  bcpu_ctrl #(.W(DW), .A(AW), .F(FW)) u_ctrl (
    .clk(clk), .rst(rst), .run(run), .mem_rdata(mem_rdata),
    .rd_a(rd_a), .rd_b(rd_b), .alu_y(alu_y),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .ra(ra), .rb(rb), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .alu_op(alu_op), .halted(halted), .illegal(illegal)
  );

  bcpu_regfile #(.W(DW), .N(NREG), .IW(FW)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr_a(ra), .rdata_a(rd_a), .raddr_b(rb), .rdata_b(rd_b)
  );

  bcpu_alu #(.W(DW)) u_alu (.op(alu_op), .a(rd_a), .b(rd_b), .y(alu_y));
endmodule

// File: tb/byte_cpu_bench.sv
module byte_cpu_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b1;
  logic [7:0] mem_rdata, mem_addr, mem_wdata;
  logic mem_we, halted, illegal;
  logic tb_we = 1'b0;
  logic [7:0] tb_addr = '0, tb_data = '0;
  logic [7:0] mem [256];
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  byte_cpu u_byte_cpu (.clk(clk), .rst(rst), .run(run), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .halted(halted), .illegal(illegal));

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    else if (tb_we) mem[tb_addr] <= tb_data;
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); tb_we = 1'b1; tb_addr = a; tb_data = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  task automatic wi(input logic [7:0] a, input logic [15:0] w);
    wr(a, w[15:8]); wr(a + 8'd1, w[7:0]);
  endtask

  task automatic clear_mem();
    rst = 1'b1;
    for (int i = 0; i < 256; i++) wr(8'(i), 8'h00);
  endtask

  task automatic go(input logic run_val);
    @(negedge clk); run = run_val; rst = 1'b0;
  endtask

  task automatic wait_halt(output int cyc);
    cyc = 0;
    while (!halted && cyc < 2000) begin
      @(posedge clk); #1; cyc++;
    end
  endtask

  function automatic logic [7:0] ror8(input logic [7:0] v, input int n);
    logic [7:0] r = v;
    for (int i = 0; i < n; i++) r = {r[0], r[7:1]};
    return r;
  endfunction

  task automatic add_run(input logic [7:0] a, input logic [7:0] b);
    int cyc;
    clear_mem();
    wi(8'h00, 16'hB0A0);
    wi(8'hA0, 16'h156C); wi(8'hA2, 16'h166D); wi(8'hA4, 16'h5056);
    wi(8'hA6, 16'h306E); wi(8'hA8, 16'hC000);
    wr(8'h6C, a); wr(8'h6D, b);
    go(1'b1); wait_halt(cyc);
    // R2 R5 R8: loads from memory, sum, taken jump to A0h
    chk(mem[8'h6E] == 8'(a + b), "R5", "sum at 6Eh", mem[8'h6E], 8'(a + b));
    chk(!illegal, "R10", "illegal on legal program", illegal, 0);
  endtask

  task automatic alu_run(input logic [7:0] a, input logic [7:0] b);
    int cyc;
    clear_mem();
    wi(8'h00, {8'h21, a}); wi(8'h02, {8'h22, b});
    wi(8'h04, 16'h5312); wi(8'h06, 16'h7412); wi(8'h08, 16'h8512); wi(8'h0A, 16'h9612);
    wi(8'h0C, 16'h3380); wi(8'h0E, 16'h3481); wi(8'h10, 16'h3582); wi(8'h12, 16'h3683);
    wi(8'h14, 16'h4019); wi(8'h16, 16'h3984); wi(8'h18, 16'hC000);
    go(1'b1); wait_halt(cyc);
    chk(mem[8'h80] == 8'(a + b), "R5", "add", mem[8'h80], 8'(a + b));
    chk(mem[8'h81] == (a | b), "R6", "or", mem[8'h81], a | b);
    chk(mem[8'h82] == (a & b), "R6", "and", mem[8'h82], a & b);
    chk(mem[8'h83] == (a ^ b), "R6", "xor", mem[8'h83], a ^ b);
    chk(mem[8'h84] == a, "R4", "move R1 to R9", mem[8'h84], a);
    // R1: 12 four-clock instructions then 3-clock halt
    chk(cyc == 51, "R1", "clock count", cyc, 51);
  endtask

  task automatic rot_run(input logic [7:0] v, input int x);
    int cyc;
    clear_mem();
    wi(8'h00, {8'h21, v}); wi(8'h02, {12'hA10, 4'(x)});
    wi(8'h04, 16'h3190); wi(8'h06, 16'hC000);
    go(1'b1); wait_halt(cyc);
    chk(mem[8'h90] == ror8(v, x), "R7", "rotated value", mem[8'h90], ror8(v, x));
    // R7: 4 + (x+4) + 4 + 3 clocks
    chk(cyc == x + 15, "R7", "rotate latency", cyc, x + 15);
  endtask

  task automatic ill_run(input logic [3:0] opc);
    int cyc;
    clear_mem();
    wi(8'h00, 16'h215A); wi(8'h02, {opc, 12'h123});
    wi(8'h04, 16'h3195); wi(8'h06, 16'hC000);
    go(1'b1); wait_halt(cyc);
    chk(illegal && halted, "R10", "illegal and halted", {illegal, halted}, 3);
    chk(mem[8'h95] == 8'h00, "R10", "store after illegal", mem[8'h95], 0);
  endtask

  initial begin
    int cyc;
    logic [7:0] hold_addr;
    void'($urandom(32'd7391));
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    chk(!halted && !illegal && !mem_we, "R11", "flags in reset", {halted, illegal, mem_we}, 0);
    chk(mem_addr == 8'h00, "R11", "address in reset", mem_addr, 0);

    add_run(8'd1, 8'd2);
    add_run(8'hFF, 8'h01);
    for (int i = 0; i < 6; i++) add_run(8'($urandom), 8'($urandom));

    alu_run(8'hF0, 8'h0F);
    alu_run(8'h80, 8'h80);
    for (int i = 0; i < 10; i++) alu_run(8'($urandom), 8'($urandom));

    rot_run(8'h65, 1);
    rot_run(8'hA7, 0);
    rot_run(8'h81, 15);
    for (int i = 0; i < 8; i++) rot_run(8'($urandom), int'($urandom % 16));

    // R8: jump not taken when R1 != R0
    clear_mem();
    wi(8'h00, 16'h2105); wi(8'h02, 16'hB10A); wi(8'h04, 16'h2277);
    wi(8'h06, 16'h3290); wi(8'h08, 16'hC000);
    go(1'b1); wait_halt(cyc);
    chk(mem[8'h90] == 8'h77, "R8", "not-taken path", mem[8'h90], 8'h77);

    // R8: jump taken when R3 == R0
    clear_mem();
    wi(8'h00, 16'h2300); wi(8'h02, 16'hB310); wi(8'h04, 16'h2255);
    wi(8'h06, 16'h3291); wi(8'h08, 16'hC000);
    wi(8'h10, 16'h2466); wi(8'h12, 16'h3491); wi(8'h14, 16'hC000);
    go(1'b1); wait_halt(cyc);
    chk(mem[8'h91] == 8'h66, "R8", "taken path", mem[8'h91], 8'h66);

    // R9: halt holds
    hold_addr = mem_addr;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      chk(halted && !mem_we && mem_addr == hold_addr, "R9", "halt hold",
          {halted, mem_we, mem_addr}, {1'b1, 1'b0, hold_addr});
    end

    ill_run(4'h0); ill_run(4'h6); ill_run(4'hD); ill_run(4'hE); ill_run(4'hF);

    // R12: run low holds the core
    clear_mem();
    wi(8'h00, 16'h2133); wi(8'h02, 16'h3196); wi(8'h04, 16'hC000);
    go(1'b0);
    repeat (30) @(posedge clk);
    #1;
    chk(!halted && mem_addr == 8'h00 && mem[8'h96] == 8'h00, "R12", "idle while run low",
        {halted, mem_addr, mem[8'h96]}, 0);
    @(negedge clk); run = 1'b1;
    wait_halt(cyc);
    chk(mem[8'h96] == 8'h33, "R12", "resumes with run", mem[8'h96], 8'h33);

    // R11: registers cleared by reset after earlier writes
    clear_mem();
    wr(8'h97, 8'hFF); wr(8'h98, 8'hFF);
    wi(8'h00, 16'h3597); wi(8'h02, 16'h3298); wi(8'h04, 16'hC000);
    go(1'b1); wait_halt(cyc);
    chk(mem[8'h97] == 8'h00 && mem[8'h98] == 8'h00, "R11", "registers after reset",
        {mem[8'h97], mem[8'h98]}, 0);
    // R3: store writes exactly the register value
    chk(cyc == 11, "R3", "two stores and halt clocks", cyc, 11);

    summary();
  end
endmodule